// File: doc/BRIEF.md
# UART Transmit Character Queue

This block is the buffer that sits between a bus-side writer and a UART serializer. Software writes characters one per cycle. The block stores up to a parameterized depth of characters (16 by default) and hands them out in arrival order over a valid/ready handshake. It reports its current occupancy, so a driver can top it up with exactly the free space, which is the depth minus the reported fill.

Two interrupt sources are derived from the occupancy, and each has its own mask. The first is "drained", which means the queue holds nothing and the serializer reports that it is idle. The second is "running low", which means the fill is under a programmable threshold; half the depth is the usual setting.

A transmit-enable input gates the handout without disturbing the stored characters. A break request holds the handout off and, one cycle later, tells the serializer to force the line low. A flush strobe throws away everything unsent. A write that arrives when the queue is full is dropped, and a sticky flag records the loss until the next flush. Serial bit timing belongs to the serializer and is not part of this block.

Top module: `uart_txq`

## Requirements
- R1: While reset is held and after it is released, fill is 0, out_valid is 0, drop_flag is 0, line_break is 0.
- R2: Characters are presented on out_data in the order they were written. A character written at a clock edge is presented from that edge on when it is at the head.
- R3: fill equals the number of stored characters, at most DEPTH (16 by default). An accepted write raises it by one, a handout (out_valid and out_ready high at an edge) lowers it by one, and both in the same cycle leave it unchanged.
- R4: A write while fill equals DEPTH is ignored: fill and the stored contents are unchanged. From the next edge, drop_flag is 1, and it stays 1 until a flush.
- R5: While tx_enable is 0, out_valid is 0 and no character is removed, whatever out_ready does. Re-enabling presents the same head character.
- R6: line_break equals brk_req delayed by one clock. While brk_req is 1, out_valid is 0 and nothing is removed.
- R7: A flush strobe at an edge makes fill 0 and drop_flag 0 after that edge. A write in the same cycle is discarded.
- R8: tx_empty is 1 exactly when fill is 0 and ser_idle is 1. irq_empty is tx_empty AND mask_empty.
- R9: irq_low is 1 exactly when mask_low is 1 and fill is strictly less than thresh.
- R10: irq is irq_empty OR irq_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | DATA_W | Character to queue |
| flush | input | 1 | Discard all unsent characters and clear drop_flag |
| tx_enable | input | 1 | Allow handout to the serializer |
| brk_req | input | 1 | Request a break condition on the line |
| thresh | input | CNT_W | Running-low threshold |
| mask_empty | input | 1 | Enable for the drained interrupt |
| mask_low | input | 1 | Enable for the running-low interrupt |
| ser_idle | input | 1 | Serializer reports no character in flight |
| out_ready | input | 1 | Serializer accepts the presented character |
| out_valid | output | 1 | A character is presented |
| out_data | output | DATA_W | Presented character |
| line_break | output | 1 | Serializer must drive the line low |
| fill | output | CNT_W | Number of stored characters |
| tx_empty | output | 1 | Queue empty and serializer idle |
| drop_flag | output | 1 | Sticky: a write hit a full queue |
| irq_empty | output | 1 | Masked drained interrupt |
| irq_low | output | 1 | Masked running-low interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the queue to its depth and writes one character more. A design that overwrote the oldest entry, or let the count wrap, would present the wrong head or report a fill of 0, and a design without the sticky flag would show no loss. It leaves out_ready high while transmit is disabled and while a break is requested; a design that gated only out_valid and not the removal would lose characters, and the fill would fall. It also flushes in the same cycle as a write and walks the fill across the threshold. An off-by-one in the threshold compare, or a drained status that ignored the serializer's idle signal, would raise the wrong interrupt.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
   // Compare rule used by the running-low interrupt
   typedef enum logic {
      LOW_STRICT    = 1'b0,
      LOW_INCLUSIVE = 1'b1
   } low_rule_e;

   function automatic int cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = uart_txq_pkg::cnt_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
   parameter int DEPTH = 16,
   parameter uart_txq_pkg::low_rule_e LOW_RULE = uart_txq_pkg::LOW_STRICT,
   localparam int CNT_W = uart_txq_pkg::cnt_width(DEPTH)
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thresh,
   input  logic             ser_idle,
   input  logic             mask_empty,
   input  logic             mask_low,
   output logic             tx_empty,
   output logic             irq_empty,
   output logic             irq_low,
   output logic             irq
);
   logic below;

   generate
      if (LOW_RULE == uart_txq_pkg::LOW_INCLUSIVE) begin : g_incl
         assign below = (count <= thresh);
      end else begin : g_strict
         assign below = (count < thresh);
      end
   endgenerate

   assign tx_empty  = (count == '0) && ser_idle;
   assign irq_empty = tx_empty && mask_empty;
   assign irq_low   = below && mask_low;
   assign irq       = irq_empty || irq_low;
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter uart_txq_pkg::low_rule_e LOW_RULE = uart_txq_pkg::LOW_STRICT,
   localparam int CNT_W = uart_txq_pkg::cnt_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flush,
   input  logic              tx_enable,
   input  logic              brk_req,
   input  logic [CNT_W-1:0]  thresh,
   input  logic              mask_empty,
   input  logic              mask_low,
   input  logic              ser_idle,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              line_break,
   output logic [CNT_W-1:0]  fill,
   output logic              tx_empty,
   output logic              drop_flag,
   output logic              irq_empty,
   output logic              irq_low,
   output logic              irq
);
   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         initial $fatal(1, "uart_txq: DEPTH must be a power of two >= 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "uart_txq: DATA_W must be positive");
      end
   endgenerate

   logic full;
   logic push;
   logic pop;
   logic brk_q;
   logic drop_q;

   assign full      = (fill == CNT_W'(DEPTH));
   assign push      = wr_en && !full && !flush;
   assign out_valid = (fill != '0) && tx_enable && !brk_req;
   assign pop       = out_valid && out_ready && !flush;

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .flush (flush),
      .wdata (wr_data),
      .rdata (out_data),
      .count (fill)
   );

   txq_irq #(.DEPTH(DEPTH), .LOW_RULE(LOW_RULE)) i_irq (
      .count      (fill),
      .thresh     (thresh),
      .ser_idle   (ser_idle),
      .mask_empty (mask_empty),
      .mask_low   (mask_low),
      .tx_empty   (tx_empty),
      .irq_empty  (irq_empty),
      .irq_low    (irq_low),
      .irq        (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_q  <= 1'b0;
         drop_q <= 1'b0;
      end else begin
         brk_q <= brk_req;
         if (flush)             drop_q <= 1'b0;
         else if (wr_en && full) drop_q <= 1'b1;
      end
   end

   assign line_break = brk_q;
   assign drop_flag  = drop_q;
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = uart_txq_pkg::cnt_width(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              flush,
   input logic              tx_enable,
   input logic              brk_req,
   input logic [CNT_W-1:0]  thresh,
   input logic              mask_empty,
   input logic              mask_low,
   input logic              ser_idle,
   input logic              out_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              line_break,
   input logic [CNT_W-1:0]  fill,
   input logic              tx_empty,
   input logic              drop_flag,
   input logic              irq_empty,
   input logic              irq_low,
   input logic              irq
);
   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   // R3
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !wr_en && !(out_valid && out_ready)) |=> $stable(fill));

   // R4
   drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fill == CNT_W'(DEPTH) && !flush && !(out_valid && out_ready))
      |=> (drop_flag && fill == CNT_W'(DEPTH)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && !flush && !wr_en) |=> $stable(fill));

   // R6
   brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |=> line_break);

   // R6
   brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> !out_valid);

   // R7
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill == '0 && !drop_flag));

   // R10
   irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (irq_empty || irq_low));

   // R8
   empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill != '0) |-> (!tx_empty && !irq_empty));
endmodule

bind uart_txq uart_txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
   .tx_enable(tx_enable), .brk_req(brk_req), .thresh(thresh),
   .mask_empty(mask_empty), .mask_low(mask_low), .ser_idle(ser_idle),
   .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
   .line_break(line_break), .fill(fill), .tx_empty(tx_empty),
   .drop_flag(drop_flag), .irq_empty(irq_empty), .irq_low(irq_low), .irq(irq)
);

// File: tb/test_uart_txq.sv
`timescale 1ns/1ps
module test_uart_txq;
   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int CW = 5;

   // Vector fields: [23] write, [22:15] data, [14] ready, [13:9] fill after
   // the edge, [8] out_valid after the edge, [7:0] expected head
   localparam logic [23:0] VEC [8] = '{
      {1'b1, 8'hA1, 1'b0, 5'd1, 1'b1, 8'hA1},
      {1'b1, 8'hB2, 1'b0, 5'd2, 1'b1, 8'hA1},
      {1'b1, 8'hC3, 1'b1, 5'd2, 1'b1, 8'hB2},
      {1'b0, 8'h00, 1'b1, 5'd1, 1'b1, 8'hC3},
      {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'h00},
      {1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'h00},
      {1'b1, 8'hD4, 1'b1, 5'd1, 1'b1, 8'hD4},
      {1'b0, 8'h00, 1'b0, 5'd1, 1'b1, 8'hD4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic flush = 1'b0;
   logic tx_enable = 1'b1;
   logic brk_req = 1'b0;
   logic [CW-1:0] thresh = 5'd8;
   logic mask_empty = 1'b0;
   logic mask_low = 1'b0;
   logic ser_idle = 1'b1;
   logic out_ready = 1'b0;
   logic out_valid;
   logic [DW-1:0] out_data;
   logic line_break;
   logic [CW-1:0] fill;
   logic tx_empty, drop_flag, irq_empty, irq_low, irq;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   uart_txq i_uart_txq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
      .tx_enable(tx_enable), .brk_req(brk_req), .thresh(thresh),
      .mask_empty(mask_empty), .mask_low(mask_low), .ser_idle(ser_idle),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .line_break(line_break), .fill(fill), .tx_empty(tx_empty),
      .drop_flag(drop_flag), .irq_empty(irq_empty), .irq_low(irq_low), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [DW-1:0] d);
      wr_en = 1'b1;
      wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      check("R1 fill", 32'(fill), 0);
      check("R1 out_valid", 32'(out_valid), 0);
      rst_n = 1'b1;
      tick();
      check("R1 drop_flag", 32'(drop_flag), 0);
      check("R1 line_break", 32'(line_break), 0);

      // Vector walk: R2 order and R3 counting
      foreach (VEC[i]) begin
         wr_en = VEC[i][23];
         wr_data = VEC[i][22:15];
         out_ready = VEC[i][14];
         tick();
         check($sformatf("R3 fill vec%0d", i), 32'(fill), 32'(VEC[i][13:9]));
         check($sformatf("R2 valid vec%0d", i), 32'(out_valid), 32'(VEC[i][8]));
         if (VEC[i][8]) check($sformatf("R2 head vec%0d", i), 32'(out_data), 32'(VEC[i][7:0]));
      end
      wr_en = 1'b0;
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
      check("R3 drained", 32'(fill), 0);

      // Fill to the depth, then one write more (R3, R4)
      for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i));
      check("R3 full fill", 32'(fill), DEPTH);
      check("R4 no drop yet", 32'(drop_flag), 0);
      push(8'hEE);
      check("R4 fill unchanged", 32'(fill), DEPTH);
      check("R4 drop set", 32'(drop_flag), 1);
      check("R4 head intact", 32'(out_data), 8'h10);
      for (int i = 0; i < DEPTH; i++) begin
         check("R2 full order", 32'(out_data), 32'(8'h10 + i));
         out_ready = 1'b1;
         tick();
      end
      out_ready = 1'b0;
      check("R3 empty after drain", 32'(fill), 0);
      check("R4 drop sticky", 32'(drop_flag), 1);
      flush = 1'b1;
      tick();
      flush = 1'b0;
      check("R7 drop cleared", 32'(drop_flag), 0);

      // R5 transmit disabled holds characters
      push(8'h55);
      push(8'h66);
      tx_enable = 1'b0;
      #1;
      check("R5 valid low", 32'(out_valid), 0);
      out_ready = 1'b1;
      repeat (3) tick();
      check("R5 fill held", 32'(fill), 2);
      out_ready = 1'b0;
      tx_enable = 1'b1;
      #1;
      check("R5 valid back", 32'(out_valid), 1);
      check("R5 head kept", 32'(out_data), 8'h55);

      // R6 break request
      brk_req = 1'b1;
      #1;
      check("R6 valid gated", 32'(out_valid), 0);
      out_ready = 1'b1;
      tick();
      check("R6 line_break set", 32'(line_break), 1);
      check("R6 fill held", 32'(fill), 2);
      brk_req = 1'b0;
      out_ready = 1'b0;
      tick();
      check("R6 line_break clear", 32'(line_break), 0);
      check("R6 valid back", 32'(out_valid), 1);

      // R7 flush wins over a same-cycle write
      flush = 1'b1;
      wr_en = 1'b1;
      wr_data = 8'h77;
      tick();
      flush = 1'b0;
      wr_en = 1'b0;
      check("R7 fill zero", 32'(fill), 0);

      // R8, R9, R10 interrupts
      mask_empty = 1'b1;
      #1;
      check("R8 tx_empty", 32'(tx_empty), 1);
      check("R8 irq_empty", 32'(irq_empty), 1);
      check("R10 irq from empty", 32'(irq), 1);
      ser_idle = 1'b0;
      #1;
      check("R8 busy serializer", 32'(tx_empty), 0);
      check("R10 irq off", 32'(irq), 0);
      mask_low = 1'b1;
      #1;
      check("R9 low at zero", 32'(irq_low), 1);
      check("R10 irq from low", 32'(irq), 1);
      for (int i = 0; i < 8; i++) push(8'(i));
      check("R9 not low at thresh", 32'(irq_low), 0);
      check("R10 irq off at thresh", 32'(irq), 0);
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
      check("R9 low below thresh", 32'(irq_low), 1);
      mask_low = 1'b0;
      #1;
      check("R9 masked", 32'(irq_low), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule